// File: doc/BRIEF.md
# Reed-Solomon Syndrome and Error-Locator Unit

This block is the front half of a decoder for a length-127 Reed-Solomon code with 119 data symbols and 8 check symbols. The code works over the 128-element field built on x^7 + x + 1. A received word streams in one 7-bit symbol per accepted beat. Each symbol carries a flag marking it as erased, meaning that no detection event was seen for it. While the word arrives, the unit accumulates the eight syndromes. When the word ends it solves for the error-locator polynomial with an inversionless Berlekamp-Massey iteration. The outcome is reported as clean, correctable or uncorrectable.

A downstream root search and magnitude stage takes the syndromes, the locator coefficients and the locator degree. The unit accepts one word at a time. Once the last symbol of a word is taken, the unit refuses input until it has pulsed done for that word. The erasure flags are counted, and the count enters the correctability decision. The flags do not change the locator.

Top module: `rs_syn_bm`

## Requirements
- R1: At done, `out_syn` holds S_j = r(α^j) for j = 1..8, where α = x and arithmetic is modulo x^7 + x + 1 (0x83). The first symbol of the word is the coefficient of the highest power of x. S_j occupies bits [7j-1 : 7j-7].
- R2: `in_ready` is high after reset and while a word is being received. It is low in the cycle after the last symbol is accepted and stays low until the clock edge that follows the done cycle. Symbols presented while it is low are ignored and do not alter the result of any word.
- R3: If all syndromes are zero, done is high in the cycle after the first rising edge that follows the edge accepting the last symbol. The verdict is clean (code 0), `out_deg` is 0, and the locator is the constant 1 (coefficient 0 equal to 1, all others 0). Erasure flags do not change this.
- R4: If any syndrome is nonzero, exactly eight solver iterations run, and done is high in the cycle after the ninth rising edge following the acceptance edge. `out_deg` is the final register length L. Coefficient i of the locator sits at bits [7i+6 : 7i].
- R5: For a word with 1 to 4 symbol errors, `out_deg` equals the number of errors. The locator, which may be scaled by any nonzero constant, has exactly that many roots among the nonzero field elements: α^(i+1) for each corrupted symbol at stream index i, counting from 0.
- R6: `out_erasures` at done equals the number of accepted symbols of that word that had `in_erase` high.
- R7: For a word that is not clean, the verdict is uncorrectable (code 2) if L > 4 or 2·L + erasure count > 8. Otherwise it is correctable (code 1).
- R8: `out_done` is a single-cycle pulse and is low out of reset. The syndromes, locator, degree, verdict and erasure count stay unchanged from done until the next word's first symbol is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A symbol is presented |
| in_sym | input | 7 | Received symbol |
| in_erase | input | 1 | Symbol is marked erased |
| in_last | input | 1 | Symbol is the final one of the word |
| in_ready | output | 1 | Unit will take the presented symbol this edge |
| out_done | output | 1 | One-cycle pulse: results are valid |
| out_verdict | output | 2 | 0 clean, 1 correctable, 2 uncorrectable |
| out_syn | output | 56 | Eight packed syndromes, S_1 in the low bits |
| out_loc | output | 63 | Nine packed locator coefficients, degree 0 in the low bits |
| out_deg | output | 4 | Locator length L |
| out_erasures | output | 8 | Count of erased symbols in the word |

## Verification
The assertions assume that every word is closed by a beat with `in_last` high and holds fewer than 256 symbols, so the erasure counter never wraps. They also assume that inputs are never unknown once reset has been released. The stimulus always sends exactly 127 symbols taken from systematically encoded random messages. It marks at most ten erasures, and it drives garbage only while `in_ready` is low, so these assumptions hold throughout. The sweep covers every error count from zero to five against erasure counts from zero to four, plus a few heavy-erasure words. Expected syndromes, latencies, verdicts and root positions are derived from the field arithmetic in the bench.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

    localparam int SYM_W = 7;
    localparam logic [SYM_W-1:0] RED_POLY = 7'h03;
    localparam int N_SYN = 8;
    localparam int T_CAP = N_SYN / 2;
    localparam int N_LOC = N_SYN + 1;
    localparam int LEN_W = $clog2(N_LOC);
    localparam int IDX_W = $clog2(N_SYN);
    localparam int CNT_W = 8;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'd0,
        ST_CORR   = 2'd1,
        ST_UNCORR = 2'd2
    } verdict_e;

    typedef enum logic [1:0] {
        PH_COLLECT = 2'd0,
        PH_EVAL    = 2'd1,
        PH_SOLVE   = 2'd2,
        PH_FIN     = 2'd3
    } phase_e;

    typedef struct packed {
        sym_t sym;
        logic erase;
        logic last;
    } beat_t;

    // Field product: shift-and-add with reduction by x^7 + x + 1.
    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[SYM_W-1] ? ((sh << 1) ^ RED_POLY) : (sh << 1);
        end
        return acc;
    endfunction

    // alpha raised to a non-negative power (alpha = x).
    function automatic sym_t gf_alpha_pow(int e);
        sym_t v;
        v = sym_t'(1);
        for (int i = 0; i < e; i++) v = gf_mul(v, sym_t'(2));
        return v;
    endfunction

endpackage

// File: rtl/rsd_syndrome.sv
module rsd_syndrome
    import rsd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take_i,
    input  logic                 first_i,
    input  sym_t                 sym_i,
    input  logic                 erase_i,
    output sym_t [N_SYN-1:0]     syn_o,
    output logic [CNT_W-1:0]     eras_o
);

    // One Horner accumulator per syndrome; each multiplies by its own root.
    for (genvar j = 0; j < N_SYN; j++) begin : g_acc
        localparam sym_t ROOT = gf_alpha_pow(j + 1);
        sym_t acc_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q <= '0;
            end else if (take_i) begin
                acc_q <= (first_i ? sym_t'(0) : gf_mul(acc_q, ROOT)) ^ sym_i;
            end
        end

        assign syn_o[j] = acc_q;
    end

    logic [CNT_W-1:0] eras_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            eras_q <= '0;
        end else if (take_i) begin
            eras_q <= (first_i ? '0 : eras_q) + CNT_W'(erase_i);
        end
    end

    assign eras_o = eras_q;

    // R1: syndromes move only when a symbol is taken
    a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> $stable(syn_o));

    // R6: within a word the erasure count never goes down
    a_r6_count_monotone: assert property (@(posedge clk) disable iff (rst)
        take_i && !first_i |=> eras_o >= $past(eras_o));

endmodule

// File: rtl/rsd_bm.sv
module rsd_bm
    import rsd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 init_i,
    input  logic                 step_i,
    input  sym_t [N_SYN-1:0]     syn_i,
    output sym_t [N_LOC-1:0]     lam_o,
    output logic [LEN_W-1:0]     len_o,
    output logic                 last_o
);

    sym_t [N_LOC-1:0] lam_q, bq_q;
    sym_t [N_LOC-1:0] lam_n, b_sh;
    sym_t             gam_q;
    sym_t             delta;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] rnd_q;
    logic             grow;

    // Discrepancy for round r: sum of lam_i * S_(r+1-i).
    always_comb begin
        delta = '0;
        for (int i = 0; i < N_SYN; i++) begin
            if (i <= int'(rnd_q))
                delta = delta ^ gf_mul(lam_q[i], syn_i[IDX_W'(int'(rnd_q) - i)]);
        end
    end

    assign grow = (delta != '0) && ({len_q, 1'b0} <= {1'b0, rnd_q});

    // Inversionless update: lam' = gamma*lam + delta*x*B.
    always_comb begin
        lam_n[0] = gf_mul(gam_q, lam_q[0]);
        for (int i = 1; i < N_LOC; i++)
            lam_n[i] = gf_mul(gam_q, lam_q[i]) ^ gf_mul(delta, bq_q[i-1]);
        b_sh = {bq_q[N_LOC-2:0], sym_t'(0)};
    end

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            lam_q    <= '0;
            lam_q[0] <= sym_t'(1);
            bq_q     <= '0;
            bq_q[0]  <= sym_t'(1);
            gam_q    <= sym_t'(1);
            len_q    <= '0;
            rnd_q    <= '0;
        end else if (step_i) begin
            lam_q <= lam_n;
            rnd_q <= rnd_q + 1'b1;
            if (grow) begin
                bq_q  <= lam_q;
                gam_q <= delta;
                len_q <= rnd_q + 1'b1 - len_q;
            end else begin
                bq_q  <= b_sh;
            end
        end
    end

    assign lam_o  = lam_q;
    assign len_o  = len_q;
    assign last_o = (rnd_q == LEN_W'(N_SYN - 1));

    // R5: the locator constant term is never lost, so roots stay meaningful
    a_r5_const_term_nonzero: assert property (@(posedge clk) disable iff (rst)
        lam_q[0] != '0);

    // R4: the register length never shrinks during a solve
    a_r4_length_grows: assert property (@(posedge clk) disable iff (rst)
        step_i |=> len_q >= $past(len_q));

    // R4: the length stays within the number of syndromes
    a_r4_length_bounded: assert property (@(posedge clk) disable iff (rst)
        len_q <= LEN_W'(N_SYN));

endmodule

// File: rtl/rs_syn_bm.sv
module rs_syn_bm
    import rsd_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [SYM_W-1:0]           in_sym,
    input  logic                       in_erase,
    input  logic                       in_last,
    output logic                       in_ready,
    output logic                       out_done,
    output logic [1:0]                 out_verdict,
    output logic [N_SYN*SYM_W-1:0]     out_syn,
    output logic [N_LOC*SYM_W-1:0]     out_loc,
    output logic [LEN_W-1:0]           out_deg,
    output logic [CNT_W-1:0]           out_erasures
);

    phase_e           phase_q;
    logic             first_q;
    logic             clean_q;
    beat_t            beat;
    logic             take;
    sym_t [N_SYN-1:0] syn;
    sym_t [N_LOC-1:0] lam;
    logic [LEN_W-1:0] len;
    logic [CNT_W-1:0] eras;
    logic             bm_init, bm_step, bm_last, syn_zero;
    logic [CNT_W:0]   weight;
    verdict_e         verdict;

    assign beat     = '{sym: in_sym, erase: in_erase, last: in_last};
    assign in_ready = (phase_q == PH_COLLECT);
    assign take     = in_valid && in_ready;
    assign syn_zero = (syn == '0);
    assign bm_init  = (phase_q == PH_EVAL);
    assign bm_step  = (phase_q == PH_SOLVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_COLLECT;
            first_q <= 1'b1;
            clean_q <= 1'b1;
        end else begin
            case (phase_q)
                PH_COLLECT: begin
                    if (take) begin
                        first_q <= beat.last;
                        if (beat.last) phase_q <= PH_EVAL;
                    end
                end
                PH_EVAL: begin
                    clean_q <= syn_zero;
                    phase_q <= syn_zero ? PH_FIN : PH_SOLVE;
                end
                PH_SOLVE: begin
                    if (bm_last) phase_q <= PH_FIN;
                end
                default: phase_q <= PH_COLLECT;
            endcase
        end
    end

    rsd_syndrome u_syn (
        .clk     (clk),
        .rst     (rst),
        .take_i  (take),
        .first_i (first_q),
        .sym_i   (beat.sym),
        .erase_i (beat.erase),
        .syn_o   (syn),
        .eras_o  (eras)
    );

    rsd_bm u_bm (
        .clk     (clk),
        .rst     (rst),
        .init_i  (bm_init),
        .step_i  (bm_step),
        .syn_i   (syn),
        .lam_o   (lam),
        .len_o   (len),
        .last_o  (bm_last)
    );

    assign weight = {{(CNT_W - LEN_W){1'b0}}, len, 1'b0} + {1'b0, eras};

    always_comb begin
        if (clean_q)
            verdict = ST_CLEAN;
        else if (len > LEN_W'(T_CAP) || weight > (CNT_W+1)'(N_SYN))
            verdict = ST_UNCORR;
        else
            verdict = ST_CORR;
    end

    assign out_done     = (phase_q == PH_FIN);
    assign out_verdict  = verdict;
    assign out_syn      = syn;
    assign out_loc      = lam;
    assign out_deg      = len;
    assign out_erasures = eras;

    // R2: taking the final symbol closes the input
    a_r2_refuse_after_last: assert property (@(posedge clk) disable iff (rst)
        take && in_last |=> !in_ready);

    // R2: input reopens right after the done cycle
    a_r2_reopen_after_done: assert property (@(posedge clk) disable iff (rst)
        out_done |=> in_ready);

    // R8: done lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);

    // R3: a clean verdict comes with zero syndromes and an empty locator
    a_r3_clean_is_zero: assert property (@(posedge clk) disable iff (rst)
        out_done && out_verdict == ST_CLEAN |-> out_syn == '0 && out_deg == '0);

    // R8: results hold in the cycle after done
    a_r8_hold_after_done: assert property (@(posedge clk) disable iff (rst)
        out_done |=> $stable(out_loc) && $stable(out_deg) && $stable(out_syn)
                     && $stable(out_verdict) && $stable(out_erasures));

endmodule

// File: tb/rs_syn_bm_bench.sv
module rs_syn_bm_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_erase, in_last;
    logic [6:0]  in_sym;
    logic        in_ready, out_done;
    logic [1:0]  out_verdict;
    logic [55:0] out_syn;
    logic [62:0] out_loc;
    logic [3:0]  out_deg;
    logic [7:0]  out_erasures;

    int n_chk = 0;
    int n_bad = 0;

    logic [6:0] alog [127];
    logic [6:0] gen  [9];

    always #10 clk = ~clk;

    rs_syn_bm u_rs_syn_bm (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym(in_sym),
        .in_erase(in_erase), .in_last(in_last), .in_ready(in_ready),
        .out_done(out_done), .out_verdict(out_verdict), .out_syn(out_syn),
        .out_loc(out_loc), .out_deg(out_deg), .out_erasures(out_erasures)
    );

    function automatic logic [6:0] fmul(logic [6:0] a, logic [6:0] b);
        logic [13:0] p;
        p = '0;
        for (int i = 0; i < 7; i++) if (b[i]) p = p ^ (14'(a) << i);
        for (int k = 13; k >= 7; k--) if (p[k]) p = p ^ (14'h83 << (k - 7));
        return p[6:0];
    endfunction

    function automatic logic [6:0] loc_at(logic [62:0] loc, logic [6:0] x);
        logic [6:0] y;
        y = '0;
        for (int i = 8; i >= 0; i--) y = fmul(y, x) ^ loc[7*i +: 7];
        return y;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_word(input int ne, input int nx, input bit poke);
        logic [6:0]  cw  [127];
        logic [6:0]  par [8];
        bit          em  [127];
        bit          xm  [127];
        logic [6:0]  fb, s;
        logic [55:0] exp_syn;
        logic [62:0] h_loc;
        logic [55:0] h_syn;
        logic [3:0]  h_deg;
        logic [1:0]  h_ver;
        logic [7:0]  h_era;
        int p, edges, exp_lat, roots, hits, exp_ver, wgt;
        bit done_seen;

        for (int i = 0; i < 8; i++) par[i] = '0;
        for (int i = 0; i < 119; i++) begin
            cw[i] = 7'($urandom % 128);
            fb = cw[i] ^ par[7];
            for (int k = 7; k >= 1; k--) par[k] = par[k-1] ^ fmul(fb, gen[k]);
            par[0] = fmul(fb, gen[0]);
        end
        for (int i = 0; i < 8; i++) cw[119+i] = par[7-i];
        for (int i = 0; i < 127; i++) begin em[i] = 1'b0; xm[i] = 1'b0; end
        for (int k = 0; k < ne; k++) begin
            do p = int'($urandom % 127); while (em[p]);
            em[p] = 1'b1;
            cw[p] = cw[p] ^ 7'(1 + ($urandom % 127));
        end
        for (int k = 0; k < nx; k++) begin
            do p = int'($urandom % 127); while (xm[p]);
            xm[p] = 1'b1;
        end

        // expected syndromes by Horner over the received word
        for (int j = 1; j <= 8; j++) begin
            s = '0;
            for (int i = 0; i < 127; i++) s = fmul(s, alog[j]) ^ cw[i];
            exp_syn[7*(j-1) +: 7] = s;
        end

        for (int i = 0; i < 127; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sym = cw[i]; in_erase = xm[i]; in_last = (i == 126);
            @(posedge clk);
        end
        @(negedge clk);
        check(in_ready == 1'b0, "R2", "ready after last", 64'(in_ready), 64'd0);
        in_valid = poke; in_sym = 7'($urandom % 128); in_erase = 1'b1; in_last = 1'b1;

        edges = 0; done_seen = 1'b0;
        while (!done_seen && edges < 30) begin
            @(posedge clk); edges++;
            @(negedge clk);
            if (out_done) done_seen = 1'b1;
            else if (poke) begin
                check(in_ready == 1'b0, "R2", "ready while busy", 64'(in_ready), 64'd0);
                in_sym = 7'($urandom % 128);
            end
        end
        in_valid = 1'b0; in_last = 1'b0; in_erase = 1'b0;

        exp_lat = (exp_syn == '0) ? 1 : 9;
        check(edges == exp_lat, (exp_lat == 1) ? "R3" : "R4", "done latency",
              64'(edges), 64'(exp_lat));
        check(out_syn == exp_syn, "R1", "syndromes", 64'(out_syn), 64'(exp_syn));
        check(out_erasures == 8'(nx), "R6", "erasure count", 64'(out_erasures), 64'(nx));

        if (ne == 0) begin
            check(out_verdict == 2'd0, "R3", "clean verdict", 64'(out_verdict), 64'd0);
            check(out_deg == 4'd0, "R3", "clean degree", 64'(out_deg), 64'd0);
            check(out_loc == 63'd1, "R3", "clean locator", 64'(out_loc), 64'd1);
        end else begin
            roots = 0; hits = 0;
            for (int e = 0; e < 127; e++) if (loc_at(out_loc, alog[e]) == '0) roots++;
            for (int i = 0; i < 127; i++)
                if (em[i] && loc_at(out_loc, alog[(i + 1) % 127]) == '0) hits++;
            if (ne <= 4) begin
                check(out_deg == 4'(ne), "R5", "locator degree", 64'(out_deg), 64'(ne));
                check(roots == ne, "R5", "root count", 64'(roots), 64'(ne));
                check(hits == ne, "R5", "roots at error positions", 64'(hits), 64'(ne));
                exp_ver = (2 * ne + nx > 8) ? 2 : 1;
            end else begin
                check(hits < ne, "R5", "five errors not all located", 64'(hits), 64'(ne - 1));
                wgt = 2 * int'(out_deg) + nx;
                exp_ver = (out_deg > 4'd4 || wgt > 8) ? 2 : 1;
            end
            check(out_verdict == 2'(exp_ver), "R7", "verdict", 64'(out_verdict), 64'(exp_ver));
        end

        h_loc = out_loc; h_syn = out_syn; h_deg = out_deg; h_ver = out_verdict; h_era = out_erasures;
        repeat (3) @(negedge clk);
        check(out_done == 1'b0, "R8", "done pulse width", 64'(out_done), 64'd0);
        check(out_loc == h_loc && out_syn == h_syn && out_deg == h_deg &&
              out_verdict == h_ver && out_erasures == h_era,
              "R8", "results held", 64'(out_loc), 64'(h_loc));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R8 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_sym = '0; in_erase = 1'b0; in_last = 1'b0;
        alog[0] = 7'd1;
        for (int e = 1; e < 127; e++) alog[e] = fmul(alog[e-1], 7'd2);
        for (int k = 0; k < 9; k++) gen[k] = '0;
        gen[0] = 7'd1;
        for (int j = 1; j <= 8; j++) begin
            for (int k = 8; k >= 1; k--) gen[k] = gen[k-1] ^ fmul(gen[k], alog[j]);
            gen[0] = fmul(gen[0], alog[j]);
        end

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R2", "ready after reset", 64'(in_ready), 64'd1);
        check(out_done == 1'b0, "R8", "done after reset", 64'(out_done), 64'd0);
        check(out_deg == 4'd0, "R4", "degree after reset", 64'(out_deg), 64'd0);

        for (int rep = 0; rep < 3; rep++)
            for (int ne = 0; ne <= 5; ne++)
                for (int nx = 0; nx <= 4; nx++)
                    run_word(ne, nx, ((ne + nx + rep) % 2) == 1);

        run_word(0, 10, 1'b1);
        run_word(1, 7, 1'b0);
        run_word(1, 6, 1'b1);
        run_word(4, 0, 1'b1);
        run_word(2, 5, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule